// File: doc/BRIEF.md
# Translation Fault Interrupt Controller

This block gathers the fault events raised by an address-translation unit and turns them into one level-sensitive interrupt for software. Three kinds of fault arrive as single-cycle pulses: a missing or invalid first-level table entry, a missing or invalid second-level table entry, and a permission violation charged to one of the bus masters behind the translator. Each kind owns a bit in a status vector. Software picks which of those bits may raise the interrupt through an enable vector, and acknowledges faults by writing a clear mask.

For every source the block keeps the address that faulted. For permission faults it also keeps the offending page entry. Only the first fault of a source is recorded. The capture is frozen until software clears that source's status bit, so a burst of repeated faults cannot overwrite the evidence. A separate master-reset vector lets software hold selected masters in reset while it recovers, then release them all at once.

Fault detection and the bus register decoder sit outside the block. The decoder presents a one-cycle write with a 2-bit target select and a data word. The capture registers are read out on dedicated output ports.

Top module: `fault_irq_ctrl`

## Requirements
- R1: A permission pulse for master m sets status bit m (m = 0..NUM_MASTERS-1). A first-level invalid-entry pulse sets status bit 16. A second-level invalid-entry pulse sets status bit 17. Each bit is visible on `status_q` one clock after the pulse. Status bits outside 17, 16 and 5:0 always read 0.
- R2: A write with `cfg_sel` = 0 loads the enable vector from `cfg_wdata`. Only bits 17, 16 and NUM_MASTERS-1:0 are stored, and every other bit reads 0.
- R3: `irq` is high exactly when some status bit is set and its enable bit is also set.
- R4: A write with `cfg_sel` = 1 clears every status bit that is 1 in `cfg_wdata`, one clock later. Status bits that are 0 in `cfg_wdata` keep their value.
- R5: When a fault pulse and a clear of the same status bit arrive in the same cycle, the bit stays set.
- R6: The per-master address and page-entry captures load only when that master's fault pulse arrives while its status bit is clear. At any other time they hold their value. They are read on `rd_err_addr` and `rd_err_data` for the master chosen by `rd_sel`. Out-of-range selects read 0.
- R7: The first-level and second-level address captures follow the same load rule as R6, using status bits 16 and 17.
- R8: A write with `cfg_sel` = 2 loads the master-reset vector from `cfg_wdata[NUM_MASTERS-1:0]`. A 0 in bit m drives `master_rst_n[m]` low, which holds master m in reset. Writing all ones releases every master.
- R9: After reset, status, enable and all captures are 0, `irq` is low, and `master_rst_n` is all ones.
- R10: A write with `cfg_sel` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perm_fault_vld | input | NUM_MASTERS | Per-master permission fault pulse |
| perm_fault_addr | input | NUM_MASTERS*ADDR_W | Faulting address, one slice per master |
| perm_fault_data | input | NUM_MASTERS*DATA_W | Offending page entry, one slice per master |
| l1_fault_vld | input | 1 | First-level invalid-entry fault pulse |
| l1_fault_addr | input | ADDR_W | Address of the first-level fault |
| l2_fault_vld | input | 1 | Second-level invalid-entry fault pulse |
| l2_fault_addr | input | ADDR_W | Address of the second-level fault |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 enable, 1 clear, 2 master reset, 3 none |
| cfg_wdata | input | 18 | Write data |
| rd_sel | input | SEL_W | Master whose captures appear on the read ports |
| irq | output | 1 | Level interrupt |
| status_q | output | 18 | Fault status vector |
| enable_q | output | 18 | Interrupt enable vector |
| master_rst_n | output | NUM_MASTERS | Per-master reset, active low |
| rd_err_addr | output | ADDR_W | Captured address of the selected master |
| rd_err_data | output | DATA_W | Captured page entry of the selected master |
| l1_err_addr | output | ADDR_W | Captured first-level fault address |
| l2_err_addr | output | ADDR_W | Captured second-level fault address |

## Verification
The hardest case to reach from the ports is a clear and a fresh fault on the same bit landing in the same clock. This case decides both whether the bit survives and whether the capture reloads. The stimulus table drives a fault pulse and a clear write together in one row. Directed tests then send a second fault with a new address while the status bit is still set, clear it, and fault again. This shows that the capture changes only on the clear-to-set transition.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int STAT_W = 18;
  localparam int L1_BIT = 16;
  localparam int L2_BIT = 17;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_MRST = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // Bits of the status/enable vectors that exist for a given master count.
  function automatic logic [STAT_W-1:0] live_mask(input int nm);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < nm; i++) m[i] = 1'b1;
    m[L1_BIT] = 1'b1;
    m[L2_BIT] = 1'b1;
    return m;
  endfunction

  // New faults win over a same-cycle clear.
  function automatic logic [STAT_W-1:0] next_status(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] set,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] mask
  );
    return ((cur & ~clr) | set) & mask;
  endfunction
endpackage

// File: rtl/fic_capture.sv
module fic_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/fic_status.sv
module fic_status
  import fic_pkg::*;
#(
  parameter int NM = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] enable_q,
  output logic              irq
);
  localparam logic [STAT_W-1:0] MASK = live_mask(NM);

  logic [STAT_W-1:0] clr_vec;

  always_comb clr_vec = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= next_status(status_q, set_vec, clr_vec, MASK);
      if (en_we) enable_q <= wdata & MASK;
    end
  end

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/fic_mrst.sv
module fic_mrst #(
  parameter int NM = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NM-1:0] wdata,
  output logic [NM-1:0] master_rst_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  master_rst_n <= '1;
    else if (we) master_rst_n <= wdata;
  end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fic_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_MASTERS-1:0]        perm_fault_vld,
  input  logic [NUM_MASTERS*ADDR_W-1:0] perm_fault_addr,
  input  logic [NUM_MASTERS*DATA_W-1:0] perm_fault_data,
  input  logic                          l1_fault_vld,
  input  logic [ADDR_W-1:0]             l1_fault_addr,
  input  logic                          l2_fault_vld,
  input  logic [ADDR_W-1:0]             l2_fault_addr,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [STAT_W-1:0]             cfg_wdata,
  input  logic [SEL_W-1:0]              rd_sel,
  output logic                          irq,
  output logic [STAT_W-1:0]             status_q,
  output logic [STAT_W-1:0]             enable_q,
  output logic [NUM_MASTERS-1:0]        master_rst_n,
  output logic [ADDR_W-1:0]             rd_err_addr,
  output logic [DATA_W-1:0]             rd_err_data,
  output logic [ADDR_W-1:0]             l1_err_addr,
  output logic [ADDR_W-1:0]             l2_err_addr
);
  localparam int CAP_W = ADDR_W + DATA_W;

  // Named internal events, brought out for the checker.
  logic [STAT_W-1:0]            set_vec;
  logic [STAT_W-1:0]            cap_load;
  logic                         en_we, clr_we, mrst_we;
  logic [NUM_MASTERS*CAP_W-1:0] perm_cap_q;

  always_comb begin
    set_vec                   = '0;
    set_vec[NUM_MASTERS-1:0]  = perm_fault_vld;
    set_vec[L1_BIT]           = l1_fault_vld;
    set_vec[L2_BIT]           = l2_fault_vld;
  end

  // First fault only: load while the status bit is still clear.
  assign cap_load = set_vec & ~status_q;

  assign en_we   = cfg_we && (cfg_sel == SEL_EN);
  assign clr_we  = cfg_we && (cfg_sel == SEL_CLR);
  assign mrst_we = cfg_we && (cfg_sel == SEL_MRST);

  fic_status #(.NM(NUM_MASTERS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_we   (clr_we),
    .en_we    (en_we),
    .wdata    (cfg_wdata),
    .status_q (status_q),
    .enable_q (enable_q),
    .irq      (irq)
  );

  fic_mrst #(.NM(NUM_MASTERS)) u_mrst (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (mrst_we),
    .wdata        (cfg_wdata[NUM_MASTERS-1:0]),
    .master_rst_n (master_rst_n)
  );

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_perm_cap
    fic_capture #(.W(CAP_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap_load[m]),
      .din   ({perm_fault_addr[m*ADDR_W +: ADDR_W], perm_fault_data[m*DATA_W +: DATA_W]}),
      .q     (perm_cap_q[m*CAP_W +: CAP_W])
    );
  end

  fic_capture #(.W(ADDR_W)) u_l1_cap (
    .clk (clk), .rst_n (rst_n), .load (cap_load[L1_BIT]),
    .din (l1_fault_addr), .q (l1_err_addr)
  );

  fic_capture #(.W(ADDR_W)) u_l2_cap (
    .clk (clk), .rst_n (rst_n), .load (cap_load[L2_BIT]),
    .din (l2_fault_addr), .q (l2_err_addr)
  );

  // Read mux; out-of-range selects return zero.
  always_comb begin
    rd_err_addr = '0;
    rd_err_data = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (32'(rd_sel) == m) begin
        rd_err_addr = perm_cap_q[m*CAP_W + DATA_W +: ADDR_W];
        rd_err_data = perm_cap_q[m*CAP_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/fic_checker.sv
module fic_checker
  import fic_pkg::*;
#(
  parameter int NM     = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [STAT_W-1:0]               set_vec,
  input logic                            clr_we,
  input logic                            mrst_we,
  input logic [STAT_W-1:0]               cfg_wdata,
  input logic [STAT_W-1:0]               status_q,
  input logic [STAT_W-1:0]               enable_q,
  input logic                            irq,
  input logic [NM-1:0]                   master_rst_n,
  input logic [NM*(ADDR_W+DATA_W)-1:0]   perm_cap_q,
  input logic [ADDR_W-1:0]               l1_err_addr,
  input logic [ADDR_W-1:0]               l2_err_addr
);
  localparam int CAP_W = ADDR_W + DATA_W;

  // R1 / R5: any fault pulse leaves its bit set next cycle, even under a clear.
  a_r1_fault_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R4: a clear with no concurrent fault removes every written bit.
  a_r4_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set_vec == '0) |=> ((status_q & $past(cfg_wdata)) == '0));

  // R3: interrupt needs both a status bit and an enable bit.
  a_r3_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);
  a_r3_no_irq_without_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq);

  // R8: master reset vector follows the written value.
  a_r8_mrst_load: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_we |=> (master_rst_n == $past(cfg_wdata[NM-1:0])));

  // R6: capture frozen while its status bit stays set.
  for (genvar m = 0; m < NM; m++) begin : g_hold
    a_r6_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_q[m]) && status_q[m]) |-> $stable(perm_cap_q[m*CAP_W +: CAP_W]));
  end

  // R7: table-level captures frozen likewise.
  a_r7_l1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q[L1_BIT]) && status_q[L1_BIT]) |-> $stable(l1_err_addr));
  a_r7_l2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q[L2_BIT]) && status_q[L2_BIT]) |-> $stable(l2_err_addr));
endmodule

bind fault_irq_ctrl fic_checker #(
  .NM(NUM_MASTERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_fic_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .set_vec      (set_vec),
  .clr_we       (clr_we),
  .mrst_we      (mrst_we),
  .cfg_wdata    (cfg_wdata),
  .status_q     (status_q),
  .enable_q     (enable_q),
  .irq          (irq),
  .master_rst_n (master_rst_n),
  .perm_cap_q   (perm_cap_q),
  .l1_err_addr  (l1_err_addr),
  .l2_err_addr  (l2_err_addr)
);

// File: tb/tb_fault_irq_ctrl.sv
`timescale 1ns/1ps
module tb_fault_irq_ctrl;
  localparam int NM = 6;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NM-1:0]   perm_fault_vld = '0;
  logic [NM*AW-1:0] perm_fault_addr = '0;
  logic [NM*DW-1:0] perm_fault_data = '0;
  logic            l1_fault_vld = 1'b0;
  logic [AW-1:0]   l1_fault_addr = '0;
  logic            l2_fault_vld = 1'b0;
  logic [AW-1:0]   l2_fault_addr = '0;
  logic            cfg_we = 1'b0;
  logic [1:0]      cfg_sel = 2'd3;
  logic [17:0]     cfg_wdata = '0;
  logic [SW-1:0]   rd_sel = '0;
  logic            irq;
  logic [17:0]     status_q, enable_q;
  logic [NM-1:0]   master_rst_n;
  logic [AW-1:0]   rd_err_addr, l1_err_addr, l2_err_addr;
  logic [DW-1:0]   rd_err_data;

  fault_irq_ctrl dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus after a falling edge; result visible at the next one.
  task automatic cycle(input logic [NM-1:0] perm, input logic l1, input logic l2,
                       input logic we, input logic [1:0] sel, input logic [17:0] wd);
    perm_fault_vld = perm; l1_fault_vld = l1; l2_fault_vld = l2;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    perm_fault_vld = '0; l1_fault_vld = 1'b0; l2_fault_vld = 1'b0;
    cfg_we = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
  endtask

  typedef struct packed {
    logic [5:0]  perm;
    logic        l1;
    logic        l2;
    logic        we;
    logic [1:0]  sel;
    logic [17:0] wdata;
    logic [17:0] exp_st;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{6'h00, 1'b0, 1'b0, 1'b1, 2'd0, 18'h3FFFF, 18'h00000, 1'b0}, // R2 enable all
    '{6'h05, 1'b0, 1'b0, 1'b0, 2'd0, 18'h00000, 18'h00005, 1'b1}, // R1 masters 0,2
    '{6'h00, 1'b0, 1'b0, 1'b1, 2'd1, 18'h00001, 18'h00004, 1'b1}, // R4 partial clear
    '{6'h00, 1'b1, 1'b0, 1'b0, 2'd0, 18'h00000, 18'h10004, 1'b1}, // R1 bit 16
    '{6'h00, 1'b0, 1'b0, 1'b1, 2'd1, 18'h10004, 18'h00000, 1'b0}, // R4 full clear
    '{6'h00, 1'b0, 1'b0, 1'b1, 2'd0, 18'h20000, 18'h00000, 1'b0}, // R2 only bit 17
    '{6'h20, 1'b0, 1'b0, 1'b0, 2'd0, 18'h00000, 18'h00020, 1'b0}, // R3 masked source
    '{6'h00, 1'b0, 1'b1, 1'b0, 2'd0, 18'h00000, 18'h20020, 1'b1}, // R3 enabled source
    '{6'h00, 1'b0, 1'b0, 1'b1, 2'd1, 18'h3FFFF, 18'h00000, 1'b0}, // R4 clear all
    '{6'h02, 1'b0, 1'b0, 1'b1, 2'd1, 18'h00002, 18'h00002, 1'b0}  // R5 fault beats clear
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 status", 64'(status_q), 64'h0);
    chk("R9 irq", 64'(irq), 64'h0);
    chk("R9 mrst", 64'(master_rst_n), 64'h3F);
    chk("R9 l1cap", 64'(l1_err_addr), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i].perm, VEC[i].l1, VEC[i].l2, VEC[i].we, VEC[i].sel, VEC[i].wdata);
      chk($sformatf("R1/R4/R5 vec%0d status", i), 64'(status_q), 64'(VEC[i].exp_st));
      chk($sformatf("R3 vec%0d irq", i), 64'(irq), 64'(VEC[i].exp_irq));
    end
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd1, 18'h3FFFF);

    // R2 unused enable bits read zero
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd0, 18'h3FFFF);
    chk("R2 enable mask", 64'(enable_q), 64'h3003F);

    // R10 select 3 changes nothing
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd3, 18'h00000);
    chk("R10 enable kept", 64'(enable_q), 64'h3003F);
    chk("R10 mrst kept", 64'(master_rst_n), 64'h3F);

    // R6 first-fault capture on master 3
    rd_sel = 3'd3;
    perm_fault_addr[3*AW +: AW] = 32'hA000_3000;
    perm_fault_data[3*DW +: DW] = 32'h1234_5031;
    cycle(6'h08, 1'b0, 1'b0, 1'b0, 2'd0, 18'h0);
    chk("R6 addr first", 64'(rd_err_addr), 64'hA000_3000);
    chk("R6 data first", 64'(rd_err_data), 64'h1234_5031);
    chk("R3 irq master3", 64'(irq), 64'h1);
    perm_fault_addr[3*AW +: AW] = 32'hB000_3000;
    perm_fault_data[3*DW +: DW] = 32'h5555_0011;
    cycle(6'h08, 1'b0, 1'b0, 1'b0, 2'd0, 18'h0);
    chk("R6 addr held", 64'(rd_err_addr), 64'hA000_3000);
    // R6 same-cycle clear+fault keeps bit set, capture unchanged
    cycle(6'h08, 1'b0, 1'b0, 1'b1, 2'd1, 18'h00008);
    chk("R6 addr held on clear race", 64'(rd_err_addr), 64'hA000_3000);
    chk("R5 bit3 kept", 64'(status_q), 64'h8);
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd1, 18'h00008);
    cycle(6'h08, 1'b0, 1'b0, 1'b0, 2'd0, 18'h0);
    chk("R6 addr reload", 64'(rd_err_addr), 64'hB000_3000);
    chk("R6 data reload", 64'(rd_err_data), 64'h5555_0011);
    rd_sel = 3'd7;
    @(negedge clk);
    chk("R6 out of range", 64'(rd_err_addr), 64'h0);

    // R7 table-level captures
    l1_fault_addr = 32'h0010_0000; l2_fault_addr = 32'h0020_1000;
    cycle('0, 1'b1, 1'b1, 1'b0, 2'd0, 18'h0);
    chk("R7 l1 first", 64'(l1_err_addr), 64'h0010_0000);
    chk("R7 l2 first", 64'(l2_err_addr), 64'h0020_1000);
    l1_fault_addr = 32'h0099_0000;
    cycle('0, 1'b1, 1'b0, 1'b0, 2'd0, 18'h0);
    chk("R7 l1 held", 64'(l1_err_addr), 64'h0010_0000);
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd1, 18'h10000);
    cycle('0, 1'b1, 1'b0, 1'b0, 2'd0, 18'h0);
    chk("R7 l1 reload", 64'(l1_err_addr), 64'h0099_0000);

    // R8 master reset
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 18'h0003A);
    chk("R8 hold masters 0,2", 64'(master_rst_n), 64'h3A);
    cycle('0, 1'b0, 1'b0, 1'b1, 2'd2, 18'h3FFFF);
    chk("R8 release all", 64'(master_rst_n), 64'h3F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule